// File: doc/BRIEF.md
# SPI Flash Transaction Engine

This block runs one serial-flash transaction at a time on a single-lane SPI port. The host selects the kind of transaction, supplies a command byte, an optional 24-bit address and a data byte count, and then pulses `start`. The engine asserts chip select and sends the command, then the address if one was asked for. A write continues with bytes taken from a small transmit FIFO of 32-bit words. A read continues by clocking in bytes that collect in a 32-bit status word. Chip select is then released and `done` is raised.

Transaction kinds are encoded on `xferKind`: 0 is command only, 1 is write and 2 is read. Code 3 behaves like command only. The serial clock comes from a divider: each half period of `sck` lasts `CLK_DIV` system clocks. A host lock input is merged with the engine's own busy state into one output, `portLock`, so that other masters stay off the port across a multi-step sequence.

Top module: `sfx_engine`

## Requirements
- R1: While reset is asserted and after it is released, with no transaction started, `csN` is 1, `sck` is 0, `done` is 0 and `statusWord` is 0.
- R2: A command-only transaction (`xferKind` 0 or 3) sends exactly the 8 command bits, MSB first, followed by the 24 address bits MSB first only when `addrEn` is 1. `byteCount` has no effect on it.
- R3: SPI mode 0 timing. `sck` idles low. `mosi` changes only on a falling `sck` edge and is stable at every rising edge. Each half period lasts `CLK_DIV` clocks, so a transaction of N bits lasts N*2*`CLK_DIV` clocks, counted from the accepted start edge to the edge that raises `done`.
- R4: A write (`xferKind` 1) sends `byteCount` data bytes after the header. The bytes come from FIFO words in the order they were pushed, each word MSB first. When the FIFO is empty, zero bytes are sent.
- R5: A read (`xferKind` 2) samples `miso` on rising `sck` edges during the data phase only. `statusWord` is cleared at start and shifts left one bit per data bit. It therefore holds the last four bytes received, with the earliest of them in bits 31:24; fewer bytes end right-justified.
- R6: `done` is 0 on the clock after an accepted start. It rises on the same edge that `csN` returns high and stays high until the next accepted start.
- R7: A `start` pulse while a transaction is running is ignored. The running transaction completes unchanged and no second transaction follows.
- R8: A pulse on `fifoReset` discards every word in the transmit FIFO.
- R9: `portLock` is 1 whenever `lockCtl` is 1 or a transaction is running, and 0 otherwise.
- R10: `csN` stays low without a break from the accepted start to the end, for a total of 8 + 24*`addrEn` + 8*`byteCount` bits (the data term counts only for write and read).
- R11: A push into a full FIFO (`FIFO_DEPTH` words) is dropped. A write longer than the stored words sends zero bytes past them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (ignored while busy) |
| xferKind | input | 2 | 0 command only, 1 write, 2 read |
| cmdByte | input | 8 | Command byte, sent first |
| addrEn | input | 1 | Send the 24-bit address phase |
| addrVal | input | 24 | Address, MSB first |
| byteCount | input | CNT_W (6) | Number of data bytes |
| fifoWrEn | input | 1 | Push `fifoWrData` into the transmit FIFO |
| fifoWrData | input | 32 | Transmit word |
| fifoReset | input | 1 | Empty the transmit FIFO |
| lockCtl | input | 1 | Host request to hold the port |
| miso | input | 1 | Serial data from the flash |
| done | output | 1 | Transaction complete flag |
| statusWord | output | 32 | Received bytes, packed MSB first |
| portLock | output | 1 | Port held for this master |
| sck | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |

## Verification
A bit counter or word counter that drifts shows up at the serial pins within one bit time: `csN` rises early or late, or a byte boundary in the captured `mosi` stream slides out of place, which the check on the total bit count catches. A FIFO pointer error shows as the wrong or repeated write bytes in the first data phase that reaches that word. A mistake in read-phase gating corrupts `statusWord` by the time `done` rises. A divider fault changes the clock count of every transaction.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  typedef enum logic [1:0] {
    KIND_CMD = 2'd0,
    KIND_WR  = 2'd1,
    KIND_RD  = 2'd2
  } xferKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHdr;     // transaction accepted: load command/address
    logic shiftTx;     // falling sck inside a word: next bit
    logic reloadFifo;  // word boundary in a write: take next FIFO word
    logic reloadZero;  // word boundary otherwise: send zeros
    logic sampleRx;    // rising sck in a read data phase
  } dpStrobe_t;

  localparam int WORD_BITS = 32;
  localparam int CMD_BITS  = 8;
  localparam int ADDR_BITS = 24;
endpackage

// File: rtl/sfx_ctrl.sv
module sfx_ctrl
  import sfx_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       kindIn,
  input  logic             addrEn,
  input  logic [CNT_W-1:0] byteCount,
  output dpStrobe_t        strb,
  output logic             sck,
  output logic             busy,
  output logic             done
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int TOT_W = CNT_W + 4;

  logic             running;
  logic [DIV_W-1:0] divCnt;
  logic             sckQ;
  logic [TOT_W-1:0] totalLeft;
  logic [5:0]       wordLeft;
  logic             inData, isWr, isRd;
  logic             tick, riseEdge, fallEdge, lastBit, wordEnd, accept;
  logic [TOT_W-1:0] hdrBits, dataBits;

  assign accept   = start && !running;
  assign tick     = running && (divCnt == DIV_W'(CLK_DIV - 1));
  assign riseEdge = tick && !sckQ;
  assign fallEdge = tick && sckQ;
  assign lastBit  = (totalLeft == TOT_W'(1));
  assign wordEnd  = (wordLeft == 6'd1);

  always_comb begin
    hdrBits  = addrEn ? TOT_W'(CMD_BITS + ADDR_BITS) : TOT_W'(CMD_BITS);
    dataBits = (kindIn == KIND_WR || kindIn == KIND_RD) ? TOT_W'({byteCount, 3'b000}) : '0;
  end

  always_comb begin
    strb            = '0;
    strb.loadHdr    = accept;
    strb.sampleRx   = riseEdge && inData && isRd;
    strb.shiftTx    = fallEdge && !lastBit && !wordEnd;
    strb.reloadFifo = fallEdge && !lastBit && wordEnd && isWr;
    strb.reloadZero = fallEdge && !lastBit && wordEnd && !isWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      divCnt    <= '0;
      sckQ      <= 1'b0;
      totalLeft <= '0;
      wordLeft  <= '0;
      inData    <= 1'b0;
      isWr      <= 1'b0;
      isRd      <= 1'b0;
      done      <= 1'b0;
    end else if (accept) begin
      running   <= 1'b1;
      divCnt    <= '0;
      sckQ      <= 1'b0;
      done      <= 1'b0;
      totalLeft <= hdrBits + dataBits;
      wordLeft  <= addrEn ? 6'd32 : 6'd8;
      inData    <= 1'b0;
      isWr      <= (kindIn == KIND_WR);
      isRd      <= (kindIn == KIND_RD);
    end else if (running) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) sckQ <= ~sckQ;
      if (fallEdge) begin
        if (lastBit) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          totalLeft <= totalLeft - 1'b1;
          if (wordEnd) begin
            wordLeft <= 6'd32;
            inData   <= 1'b1;
          end else begin
            wordLeft <= wordLeft - 1'b1;
          end
        end
      end
    end
  end

  assign sck  = sckQ;
  assign busy = running;
endmodule

// File: rtl/sfx_datapath.sv
module sfx_datapath
  import sfx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic [7:0]           cmdByte,
  input  logic                 addrEn,
  input  logic [23:0]          addrVal,
  input  logic                 fifoWrEn,
  input  logic [WORD_BITS-1:0] fifoWrData,
  input  logic                 fifoReset,
  input  logic                 miso,
  output logic                 mosi,
  output logic [WORD_BITS-1:0] statusWord
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  logic [WORD_BITS-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]     wrPtr, rdPtr;
  logic [PTR_W:0]       level;
  logic                 full, empty, push, pop;
  logic [WORD_BITS-1:0] txShift, rxWord;

  assign full  = (level == (PTR_W+1)'(FIFO_DEPTH));
  assign empty = (level == '0);
  assign push  = fifoWrEn && !full && !fifoReset;
  assign pop   = strb.reloadFifo && !empty && !fifoReset;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= fifoWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (fifoReset) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      level <= level + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxWord  <= '0;
    end else begin
      if (strb.loadHdr)         txShift <= {cmdByte, addrEn ? addrVal : 24'h0};
      else if (strb.shiftTx)    txShift <= {txShift[WORD_BITS-2:0], 1'b0};
      else if (strb.reloadFifo) txShift <= empty ? '0 : mem[rdPtr];
      else if (strb.reloadZero) txShift <= '0;

      if (strb.loadHdr)       rxWord <= '0;
      else if (strb.sampleRx) rxWord <= {rxWord[WORD_BITS-2:0], miso};
    end
  end

  assign mosi       = txShift[WORD_BITS-1];
  assign statusWord = rxWord;
endmodule

// File: rtl/sfx_engine.sv
module sfx_engine
  import sfx_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int CNT_W      = 6,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       xferKind,
  input  logic [7:0]       cmdByte,
  input  logic             addrEn,
  input  logic [23:0]      addrVal,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             fifoWrEn,
  input  logic [31:0]      fifoWrData,
  input  logic             fifoReset,
  input  logic             lockCtl,
  input  logic             miso,
  output logic             done,
  output logic [31:0]      statusWord,
  output logic             portLock,
  output logic             sck,
  output logic             csN,
  output logic             mosi
);
  dpStrobe_t strb;
  logic      busy;

  sfx_ctrl #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .kindIn(xferKind),
    .addrEn(addrEn), .byteCount(byteCount), .strb(strb),
    .sck(sck), .busy(busy), .done(done)
  );

  sfx_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdByte(cmdByte),
    .addrEn(addrEn), .addrVal(addrVal), .fifoWrEn(fifoWrEn),
    .fifoWrData(fifoWrData), .fifoReset(fifoReset), .miso(miso),
    .mosi(mosi), .statusWord(statusWord)
  );

  assign csN      = ~busy;
  assign portLock = lockCtl | busy;
endmodule

// File: rtl/sfx_checker.sv
module sfx_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic lockCtl,
  input logic done,
  input logic portLock,
  input logic sck,
  input logic csN,
  input logic mosi
);
  assert_sck_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> $stable(mosi));

  assert_mosi_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN) && !$stable(mosi)) |-> $fell(sck));

  assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (start && csN) |=> !done);

  assert_done_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> $rose(done));

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_lock_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!csN || lockCtl) |-> portLock);
endmodule

bind sfx_engine sfx_checker u_sfx_checker (
  .clk(clk), .rstN(rstN), .start(start), .lockCtl(lockCtl), .done(done),
  .portLock(portLock), .sck(sck), .csN(csN), .mosi(mosi)
);

// File: tb/test_sfx_engine.sv
module test_sfx_engine;
  localparam int CLK_DIV = 2, CNT_W = 6, FIFO_DEPTH = 8;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, addrEn = 1'b0;
  logic [1:0] xferKind = '0;
  logic [7:0] cmdByte = '0;
  logic [23:0] addrVal = '0;
  logic [CNT_W-1:0] byteCount = '0;
  logic fifoWrEn = 1'b0, fifoReset = 1'b0, lockCtl = 1'b0, miso = 1'b0;
  logic [31:0] fifoWrData = '0;
  logic done, portLock, sck, csN, mosi;
  logic [31:0] statusWord;

  sfx_engine #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) i_sfx_engine (
    .clk(clk), .rstN(rstN), .start(start), .xferKind(xferKind), .cmdByte(cmdByte),
    .addrEn(addrEn), .addrVal(addrVal), .byteCount(byteCount), .fifoWrEn(fifoWrEn),
    .fifoWrData(fifoWrData), .fifoReset(fifoReset), .lockCtl(lockCtl), .miso(miso),
    .done(done), .statusWord(statusWord), .portLock(portLock), .sck(sck),
    .csN(csN), .mosi(mosi)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, fails = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // flash slave model, mode 0
  function automatic logic [7:0] slaveByte(int k);
    return 8'h3C ^ 8'(k * 37);
  endfunction
  function automatic logic slaveBit(int i);
    logic [7:0] b;
    b = slaveByte(i / 8);
    return b[7 - (i % 8)];
  endfunction
  function automatic logic [31:0] fifoWord(int i);
    return 32'h1F2E3D4C ^ (i * 32'h01030507);
  endfunction

  int misoIdx = 0, capBits = 0;
  logic [7:0] capBytes [0:63];

  always @(negedge csN) begin
    misoIdx = 0;
    capBits = 0;
    miso = slaveBit(0);
  end
  always @(negedge sck) if (!csN) begin
    misoIdx++;
    miso = slaveBit(misoIdx);
  end
  always @(posedge sck) if (!csN) begin
    if (capBits < 512) capBytes[capBits / 8][7 - (capBits % 8)] = mosi;
    capBits++;
  end

  // scoreboard
  typedef struct packed {
    logic [31:0]       status;
    logic [15:0]       bits;
    logic [63:0][7:0]  bytes;
  } item_t;
  item_t expQ[$];
  string tagQ[$];

  initial forever begin
    item_t it;
    string tg;
    int bad;
    @(posedge done);
    #2;
    if (expQ.size() == 0) begin
      chk(0, "R7", "unexpected completion", 1, 0);
    end else begin
      it = expQ.pop_front();
      tg = tagQ.pop_front();
      chk(capBits == int'(it.bits), tg, "bit count", capBits, it.bits);
      bad = -1;
      for (int i = 0; i < int'(it.bits) / 8; i++)
        if (bad < 0 && capBytes[i] !== it.bytes[i]) bad = i;
      chk(bad < 0, tg, "mosi byte stream", (bad < 0) ? 0 : capBytes[bad],
          (bad < 0) ? 0 : it.bytes[bad]);
      chk(statusWord == it.status, tg, "statusWord", statusWord, it.status);
    end
  end

  task automatic pushWords(int n, int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fifoWrEn = 1'b1;
      fifoWrData = fifoWord(base + i);
    end
    @(negedge clk);
    fifoWrEn = 1'b0;
  endtask

  task automatic fifoClear();
    @(negedge clk);
    fifoReset = 1'b1;
    @(negedge clk);
    fifoReset = 1'b0;
  endtask

  task automatic runXfer(string tag, logic [1:0] kind, logic [7:0] cmd, logic ae,
                         logic [23:0] addr, int cnt, int avail, int base, bit poke);
    item_t it;
    int hdr, nData, cyc;
    bit gap;
    logic [31:0] w;
    it = '0;
    hdr = ae ? 4 : 1;
    nData = (kind == 2'd1 || kind == 2'd2) ? cnt : 0;
    it.bits = 16'(8 * (hdr + nData));
    it.bytes[0] = cmd;
    if (ae) begin
      it.bytes[1] = addr[23:16];
      it.bytes[2] = addr[15:8];
      it.bytes[3] = addr[7:0];
    end
    for (int k = 0; k < nData; k++) begin
      if (kind == 2'd1) begin
        w = (k / 4 < avail) ? fifoWord(base + k / 4) : 32'h0;
        it.bytes[hdr + k] = w[31 - 8 * (k % 4) -: 8];
      end else begin
        it.bytes[hdr + k] = 8'h00;
        it.status = {it.status[23:0], slaveByte(hdr + k)};
      end
    end
    expQ.push_back(it);
    tagQ.push_back(tag);

    @(negedge clk);
    xferKind = kind; cmdByte = cmd; addrEn = ae; addrVal = addr;
    byteCount = CNT_W'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R6", "done after start", done, 0);
    chk(csN == 1'b0, "R10", "csN after start", csN, 0);
    chk(portLock == 1'b1, "R9", "portLock while busy", portLock, 1);
    cyc = 0;
    gap = 1'b0;
    while (!done) begin
      if (poke && cyc == 40) begin
        cmdByte = ~cmd;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (csN && !done) gap = 1'b1;
    end
    start = 1'b0;
    chk(!gap, "R10", "csN break", gap, 0);
    chk(cyc == int'(it.bits) * 2 * CLK_DIV, "R3", "clocks per transaction", cyc,
        int'(it.bits) * 2 * CLK_DIV);
    if (poke) begin
      gap = 1'b0;
      repeat (30) begin
        @(negedge clk);
        if (!csN) gap = 1'b1;
      end
      chk(!gap, "R7", "second transaction after ignored start", gap, 0);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(csN == 1'b1 && sck == 1'b0, "R1", "pins in reset", {csN, sck}, 2'b10);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(csN == 1'b1, "R1", "csN idle", csN, 1);
    chk(sck == 1'b0, "R1", "sck idle", sck, 0);
    chk(done == 1'b0, "R1", "done idle", done, 0);
    chk(statusWord == 32'h0, "R1", "statusWord idle", statusWord, 0);
    chk(portLock == 1'b0, "R9", "portLock idle unlocked", portLock, 0);
    lockCtl = 1'b1;
    @(negedge clk);
    chk(portLock == 1'b1, "R9", "portLock on host lock", portLock, 1);
    lockCtl = 1'b0;
    @(negedge clk);
    chk(portLock == 1'b0, "R9", "portLock released", portLock, 0);

    // R2: command only, with and without address; count ignored
    runXfer("R2", 2'd0, 8'h06, 1'b0, 24'h0, 5, 0, 0, 0);
    runXfer("R2", 2'd0, 8'hD8, 1'b1, 24'h012345, 9, 0, 0, 0);
    runXfer("R2", 2'd3, 8'h04, 1'b0, 24'h0, 3, 0, 0, 0);
    chk(done == 1'b1, "R6", "done held while idle", done, 1);
    // R5: reads of 1, 4 and 6 bytes, and 0 bytes
    runXfer("R5", 2'd2, 8'h0F, 1'b1, 24'hC00000, 1, 0, 0, 0);
    runXfer("R5", 2'd2, 8'h03, 1'b1, 24'h000800, 4, 0, 0, 0);
    runXfer("R5", 2'd2, 8'h9F, 1'b0, 24'h0, 6, 0, 0, 0);
    runXfer("R5", 2'd2, 8'h13, 1'b1, 24'h000040, 0, 0, 0, 0);
    // R4: write with empty FIFO, then with two words and a partial last word
    fifoClear();
    runXfer("R4", 2'd1, 8'h84, 1'b1, 24'h000100, 4, 0, 0, 0);
    fifoClear();
    pushWords(2, 10);
    runXfer("R4", 2'd1, 8'h84, 1'b1, 24'h000000, 6, 2, 10, 0);
    // R11: nine pushes into an eight-word FIFO, 36-byte write
    fifoClear();
    pushWords(9, 20);
    runXfer("R11", 2'd1, 8'h02, 1'b0, 24'h0, 36, FIFO_DEPTH, 20, 0);
    // R8: reset drops earlier words
    fifoClear();
    pushWords(2, 100);
    fifoClear();
    pushWords(1, 200);
    runXfer("R8", 2'd1, 8'h84, 1'b1, 24'h000200, 4, 1, 200, 0);
    // R7: start pulse in the middle of a read
    runXfer("R7", 2'd2, 8'h03, 1'b1, 24'h000010, 4, 0, 0, 1);

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule